// File: doc/BRIEF.md
# Parallel ADC Read Sequencer

This block sits on the host side of a 14-bit successive-approximation converter that has a parallel three-state data bus. One accepted start request produces one full conversion cycle. The sequencer pulls chip-select low with the read/convert line low to open acquisition, and holds it there for a set number of clocks. It then lifts chip-select for one clock and pulls it low again to launch conversion. It waits for the converter's end-of-conversion flag to fall. It then raises read/convert, produces a third chip-select falling edge so that the converter drives its result, and latches the bus once a programmable access time has elapsed.

Two build variants are chosen by a parameter. In word mode the 14-bit result is read in one access. In byte mode the low byte is read with the byte-select line low. The line is then raised with chip-select still low, and the upper six bits are read. The assembled unsigned word is held on a valid/ready output until the consumer takes it. A separate request pulses the converter's reset pin with chip-select high, which removes the need for a dummy conversion after power-up. A conversion that never finishes is abandoned after a programmable timeout, and an error flag is raised.

Top module: `adc_read_seq`

## Requirements
- R1: While and just after reset: chip-select is high, read/convert, byte-select and converter reset are low, and result-valid and error are low.
- R2: A start request accepted in idle drives chip-select low with read/convert low for exactly ACQ_CYC clocks (acquisition). Chip-select is then high for one clock, and it then falls again with read/convert low (conversion start).
- R3: Chip-select has exactly three falling edges per completed cycle. Read/convert never changes while chip-select is low, and the third falling edge, which has read/convert high, follows only after the end-of-conversion input falls.
- R4: The data bus is latched only at the end of ACC_CYC clocks of chip-select low with read/convert high. Whatever the bus carries at any other time never reaches the result.
- R5: In byte mode (BYTE_MODE=1, 8-bit bus) the first access has byte-select low and supplies result bits 7:0. The second access, in the same chip-select low period, has byte-select high, and its bus bits 5:0 supply result bits 13:8.
- R6: In word mode (BYTE_MODE=0, 14-bit bus) one access supplies all 14 result bits.
- R7: Once the read completes, chip-select is high, and it stays high while a result is pending.
- R8: Result data and valid stay stable until ready is high. Start requests made while a result is pending are ignored, and after the handshake valid drops and no cycle begins without a new start.
- R9: If the end-of-conversion input does not fall within TIMEOUT_CYC clocks of conversion start, chip-select returns high, the error flag rises and no result is presented. The flag clears when the next start is accepted.
- R10: A reset request in idle pulses the converter reset output for exactly RST_CYC clocks with chip-select high throughout. A later start then runs a normal cycle.
- R11: The host bus output-enable is never asserted.
- R12: Codes are unsigned: 14'h0000 and 14'h3FFF arrive unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request one conversion cycle (taken in idle) |
| resetReq | input | 1 | Request a converter reset pulse (taken in idle) |
| adcEndConv | input | 1 | End-of-conversion flag; its falling edge marks result ready |
| adcBus | input | BusW | Converter data bus (8 in byte mode, 14 in word mode) |
| resultReady | input | 1 | Consumer accepts the result |
| adcCsN | output | 1 | Converter chip-select, active low |
| adcRdConv | output | 1 | Read/convert select: low for acquire/convert, high for read |
| adcByteHi | output | 1 | Byte select: high picks the upper byte |
| adcRstOut | output | 1 | Converter reset pulse |
| hostBusOe | output | 1 | Host drive enable for the data bus, held low |
| resultValid | output | 1 | Result word is available |
| resultData | output | 14 | Assembled unsigned result |
| errFlag | output | 1 | Conversion timed out |

## Verification
A controller that enters the wrong state shows this within one clock as the wrong chip-select count or run length, or as read/convert toggling under a low chip-select. The edge counts and the acquisition length are measured directly at the pins. A wrong access count or a swapped byte-select shows up as a corrupted result word. This is because the converter model drives a poison pattern whenever the bus is not legitimately driven. A missing timeout makes the cycle hang, while a lost hold keeps chip-select low or drops valid before the handshake. Both are visible in the cycles that follow.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [3:0] {
    stIdle,
    stRst,
    stAcq,
    stGap1,
    stConv,
    stGap2,
    stRdLo,
    stRdHi,
    stHold
  } seqState_t;

  typedef struct packed {
    logic capLo;
    logic capHi;
    logic publish;
  } dpStrobe_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int BYTE_MODE   = 1,
  parameter int ACQ_CYC     = 4,
  parameter int ACC_CYC     = 2,
  parameter int TIMEOUT_CYC = 40,
  parameter int RST_CYC     = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      resetReq,
  input  logic      adcEndConv,
  input  logic      resultReady,
  output logic      csN,
  output logic      rdConv,
  output logic      byteHi,
  output logic      rstOut,
  output logic      errFlag,
  output dpStrobe_t stb
);

  localparam int MaxA   = (ACQ_CYC > ACC_CYC) ? ACQ_CYC : ACC_CYC;
  localparam int MaxB   = (TIMEOUT_CYC > RST_CYC) ? TIMEOUT_CYC : RST_CYC;
  localparam int MaxCyc = (MaxA > MaxB) ? MaxA : MaxB;
  localparam int CntW   = $clog2(MaxCyc + 1);

  seqState_t state, nxt;
  logic [CntW-1:0] cnt;
  logic eocS1, eocS2, eocPrev;
  logic eocFall, timeoutHit;

  // two-flop synchroniser and falling-edge detector for end of conversion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eocS1   <= 1'b0;
      eocS2   <= 1'b0;
      eocPrev <= 1'b0;
    end else begin
      eocS1   <= adcEndConv;
      eocS2   <= eocS1;
      eocPrev <= eocS2;
    end
  end
  assign eocFall = eocPrev & ~eocS2;

  assign timeoutHit = (state == stConv) && !eocFall &&
                      (cnt == CntW'(TIMEOUT_CYC - 1));

  always_comb begin
    nxt = state;
    stb = '0;
    unique case (state)
      stIdle: begin
        if (resetReq)      nxt = stRst;
        else if (startReq) nxt = stAcq;
      end
      stRst:  if (cnt == CntW'(RST_CYC - 1)) nxt = stIdle;
      stAcq:  if (cnt == CntW'(ACQ_CYC - 1)) nxt = stGap1;
      stGap1: nxt = stConv;
      stConv: begin
        if (eocFall)         nxt = stGap2;
        else if (timeoutHit) nxt = stIdle;
      end
      stGap2: nxt = stRdLo;
      stRdLo: begin
        if (cnt == CntW'(ACC_CYC - 1)) begin
          stb.capLo = 1'b1;
          if (BYTE_MODE != 0) begin
            nxt = stRdHi;
          end else begin
            nxt         = stHold;
            stb.publish = 1'b1;
          end
        end
      end
      stRdHi: begin
        if (cnt == CntW'(ACC_CYC - 1)) begin
          stb.capHi   = 1'b1;
          stb.publish = 1'b1;
          nxt         = stHold;
        end
      end
      stHold: if (resultReady) nxt = stIdle;
      default: nxt = stIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= stIdle;
      cnt     <= '0;
      errFlag <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
      if (timeoutHit)
        errFlag <= 1'b1;
      else if (state == stIdle && nxt == stAcq)
        errFlag <= 1'b0;
    end
  end

  assign csN    = !(state inside {stAcq, stConv, stRdLo, stRdHi});
  assign rdConv = state inside {stGap2, stRdLo, stRdHi};
  assign byteHi = (state == stRdHi);
  assign rstOut = (state == stRst);

  // read/convert may only move while chip-select is high
  assert_rc_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> (rdConv == $past(rdConv)));

  // converter reset only with chip-select high
  assert_rst_cs_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    rstOut |-> csN);

  // a raised error always leaves the converter deselected
  assert_err_cs_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> csN);

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int BYTE_MODE = 1,
  parameter int RES_W     = 14,
  parameter int BUS_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [BUS_W-1:0] adcBus,
  input  logic             resultReady,
  output logic [RES_W-1:0] resultData,
  output logic             resultValid
);

  generate
    if (BYTE_MODE != 0) begin : g_byte
      localparam int HiW = RES_W - BUS_W;
      logic [BUS_W-1:0] loReg, hiReg;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          loReg <= '0;
          hiReg <= '0;
        end else begin
          if (stb.capLo) loReg <= adcBus;
          if (stb.capHi) hiReg <= adcBus;
        end
      end
      assign resultData = {hiReg[HiW-1:0], loReg};
      if (HiW < BUS_W) begin : g_spare
        logic unusedHiBits;
        assign unusedHiBits = ^hiReg[BUS_W-1:HiW];
      end
    end else begin : g_word
      logic [RES_W-1:0] wordReg;
      logic unusedCapHi;
      always_ff @(posedge clk) begin
        if (!rstN)          wordReg <= '0;
        else if (stb.capLo) wordReg <= adcBus;
      end
      assign resultData  = wordReg;
      assign unusedCapHi = stb.capHi;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                          resultValid <= 1'b0;
    else if (stb.publish)               resultValid <= 1'b1;
    else if (resultValid && resultReady) resultValid <= 1'b0;
  end

  // pending word and flag must not move until taken
  assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !resultReady) |=> (resultValid && $stable(resultData)));

  // control may not publish over an untaken word
  assert_publish_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.publish |-> !resultValid);

endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
  import adc_seq_pkg::*;
#(
  parameter int BYTE_MODE   = 1,
  parameter int RES_W       = 14,
  parameter int ACQ_CYC     = 4,
  parameter int ACC_CYC     = 2,
  parameter int TIMEOUT_CYC = 40,
  parameter int RST_CYC     = 3,
  localparam int BusW       = (BYTE_MODE != 0) ? 8 : RES_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            resetReq,
  input  logic            adcEndConv,
  input  logic [BusW-1:0] adcBus,
  input  logic            resultReady,
  output logic            adcCsN,
  output logic            adcRdConv,
  output logic            adcByteHi,
  output logic            adcRstOut,
  output logic            hostBusOe,
  output logic            resultValid,
  output logic [RES_W-1:0] resultData,
  output logic            errFlag
);

  dpStrobe_t stb;

  adc_seq_ctrl #(
    .BYTE_MODE(BYTE_MODE), .ACQ_CYC(ACQ_CYC), .ACC_CYC(ACC_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC), .RST_CYC(RST_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .resetReq(resetReq),
    .adcEndConv(adcEndConv), .resultReady(resultReady),
    .csN(adcCsN), .rdConv(adcRdConv), .byteHi(adcByteHi),
    .rstOut(adcRstOut), .errFlag(errFlag), .stb(stb)
  );

  adc_seq_dp #(
    .BYTE_MODE(BYTE_MODE), .RES_W(RES_W), .BUS_W(BusW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .adcBus(adcBus),
    .resultReady(resultReady), .resultData(resultData),
    .resultValid(resultValid)
  );

  assign hostBusOe = 1'b0;

  // the converter is released while a word waits for its consumer
  assert_valid_cs_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> adcCsN);

endmodule

// File: tb/adc_read_seq_bench.sv
module adc_conv_model #(
  parameter int BYTE_MODE = 1,
  parameter int BUS_W     = 8
) (
  input  logic             clk,
  input  logic             csN,
  input  logic             rdConv,
  input  logic             byteHi,
  input  logic             rstIn,
  input  logic [13:0]      code,
  input  int               convCyc,
  input  logic             hang,
  output logic             eoc,
  output logic [BUS_W-1:0] bus
);
  logic csPrev = 1'b1;
  int   phase  = 0;
  int   cntDown = 0;
  logic [15:0] full;

  initial eoc = 1'b0;

  always @(posedge clk) begin
    csPrev <= csN;
    if (rstIn) begin
      phase <= 0;
      eoc   <= 1'b0;
    end else if (csPrev && !csN) begin
      if (rdConv) phase <= 3;
      else if (phase == 1) begin
        phase   <= 2;
        eoc     <= 1'b1;
        cntDown <= convCyc;
      end else begin
        phase <= 1;
        eoc   <= 1'b0;
      end
    end else if (!csPrev && csN && phase == 3) begin
      phase <= 0;
    end else if (phase == 2 && eoc && !hang) begin
      if (cntDown <= 1) eoc <= 1'b0;
      else cntDown <= cntDown - 1;
    end
  end

  always_comb begin
    if (BYTE_MODE != 0) full = byteHi ? {10'b0, code[13:8]} : {8'b0, code[7:0]};
    else full = {2'b0, code};
    if (phase == 3 && !csN && rdConv) bus = full[BUS_W-1:0];
    else bus = BUS_W'(16'hA5C3);
  end
endmodule

module adc_read_seq_bench;
  localparam int ACQ = 4, ACC = 2, TMO = 40, RSTC = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic startB = 0, startW = 0, resetB = 0, resetW = 0, readyB = 0, readyW = 0;
  logic [13:0] codeB = '0, codeW = '0;
  int convB = 5, convW = 5;
  logic hangB = 0;

  logic eocB, eocW;
  logic [7:0] busB;
  logic [13:0] busW;
  logic csB, rcB, bhB, rsB, oeB, vB, erB;
  logic csW, rcW, bhW, rsW, oeW, vW, erW;
  logic [13:0] dB, dW;

  adc_read_seq #(.BYTE_MODE(1), .ACQ_CYC(ACQ), .ACC_CYC(ACC), .TIMEOUT_CYC(TMO), .RST_CYC(RSTC))
  u_adc_read_seq (
    .clk(clk), .rstN(rstN), .startReq(startB), .resetReq(resetB), .adcEndConv(eocB),
    .adcBus(busB), .resultReady(readyB), .adcCsN(csB), .adcRdConv(rcB), .adcByteHi(bhB),
    .adcRstOut(rsB), .hostBusOe(oeB), .resultValid(vB), .resultData(dB), .errFlag(erB));

  adc_read_seq #(.BYTE_MODE(0), .ACQ_CYC(ACQ), .ACC_CYC(ACC), .TIMEOUT_CYC(TMO), .RST_CYC(RSTC))
  u_adc_read_seq_w (
    .clk(clk), .rstN(rstN), .startReq(startW), .resetReq(resetW), .adcEndConv(eocW),
    .adcBus(busW), .resultReady(readyW), .adcCsN(csW), .adcRdConv(rcW), .adcByteHi(bhW),
    .adcRstOut(rsW), .hostBusOe(oeW), .resultValid(vW), .resultData(dW), .errFlag(erW));

  adc_conv_model #(.BYTE_MODE(1), .BUS_W(8)) u_modelB (
    .clk(clk), .csN(csB), .rdConv(rcB), .byteHi(bhB), .rstIn(rsB), .code(codeB),
    .convCyc(convB), .hang(hangB), .eoc(eocB), .bus(busB));
  adc_conv_model #(.BYTE_MODE(0), .BUS_W(14)) u_modelW (
    .clk(clk), .csN(csW), .rdConv(rcW), .byteHi(bhW), .rstIn(rsW), .code(codeW),
    .convCyc(convW), .hang(1'b0), .eoc(eocW), .bus(busW));

  int checks = 0, errors = 0, cycles = 0;

  // pin monitors
  int fallB = 0, fallW = 0, runB = 0, acqLenB = 0, acqLenW = 0, runW = 0;
  int rstCntB = 0, rstCsLowB = 0, oeSeen = 0;
  logic prevB = 1'b1, prevW = 1'b1;
  always @(posedge clk) begin
    if (prevB && !csB) fallB++;
    if (prevW && !csW) fallW++;
    if (!csB) runB++;
    else if (runB > 0) begin if (fallB == 1) acqLenB = runB; runB = 0; end
    if (!csW) runW++;
    else if (runW > 0) begin if (fallW == 1) acqLenW = runW; runW = 0; end
    if (rsB) begin rstCntB++; if (!csB) rstCsLowB++; end
    if (oeB || oeW) oeSeen++;
    prevB = csB;
    prevW = csW;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  localparam logic [13:0] VEC [8] = '{14'h0000, 14'h3FFF, 14'h2AAA, 14'h1555,
                                     14'h0001, 14'h2000, 14'h00FF, 14'h3F00};

  task automatic clearMon();
    fallB = 0; fallW = 0; acqLenB = 0; acqLenW = 0;
  endtask

  task automatic pulseStart(input bit b, input bit w);
    @(negedge clk);
    clearMon();
    startB = b; startW = w;
    @(negedge clk);
    startB = 0; startW = 0;
  endtask

  task automatic waitValid(input bit b, input bit w);
    while (!((vB || !b) && (vW || !w))) @(negedge clk);
  endtask

  task automatic takeResult();
    readyB = 1; readyW = 1;
    @(negedge clk);
    readyB = 0; readyW = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(csB && csW, "R1 csN", {csB, csW}, 2'b11);
    check(!rcB && !bhB && !rsB && !rcW && !rsW, "R1 ctl", {rcB, bhB, rsB}, 0);
    check(!vB && !vW && !erB && !erW, "R1 flags", {vB, vW, erB, erW}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      codeB = VEC[i]; codeW = VEC[i] ^ 14'h0F0F;
      if (i < 2) codeW = VEC[i];
      convB = 5 + i; convW = 12 - i;
      pulseStart(1, 1);
      waitValid(1, 1);
      check(dB == codeB, (i < 2) ? "R12 byte" : "R5 byte", dB, codeB);
      check(dW == codeW, (i < 2) ? "R12 word" : "R6 word", dW, codeW);
      check(csB && csW, "R7 cs released", {csB, csW}, 2'b11);
      check(fallB == 3 && fallW == 3, "R3 falls", fallB * 16 + fallW, 8'h33);
      check(acqLenB == ACQ && acqLenW == ACQ, "R2 acq len", acqLenB, ACQ);
      takeResult();
    end

    // R8: hold until ready, starts ignored
    codeB = 14'h1234; convB = 6;
    pulseStart(1, 0);
    waitValid(1, 0);
    begin
      logic [13:0] held;
      int csLow;
      held = dB; csLow = 0;
      for (int k = 0; k < 10; k++) begin
        startB = (k == 3);
        @(negedge clk);
        if (!csB || !vB || dB != held) csLow++;
      end
      startB = 0;
      check(csLow == 0, "R8 hold", csLow, 0);
      check(dB == 14'h1234, "R4 data", dB, 14'h1234);
      takeResult();
      check(!vB, "R8 valid drop", vB, 0);
      csLow = 0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (!csB) csLow++;
      end
      check(csLow == 0, "R8 start ignored", csLow, 0);
    end

    // R9: timeout
    hangB = 1;
    pulseStart(1, 0);
    repeat (TMO + 15) @(negedge clk);
    check(erB == 1'b1, "R9 err", erB, 1);
    check(csB && !vB, "R9 cs/valid", {csB, vB}, 2'b10);
    hangB = 0; codeB = 14'h2BCD; convB = 7;
    pulseStart(1, 0);
    check(!erB, "R9 err clear", erB, 0);
    waitValid(1, 0);
    check(dB == 14'h2BCD, "R9 recover", dB, 14'h2BCD);
    takeResult();

    // R10: reset pulse
    @(negedge clk);
    rstCntB = 0; rstCsLowB = 0;
    resetB = 1;
    @(negedge clk);
    resetB = 0;
    repeat (8) @(negedge clk);
    check(rstCntB == RSTC, "R10 pulse len", rstCntB, RSTC);
    check(rstCsLowB == 0, "R10 cs high", rstCsLowB, 0);
    codeB = 14'h0C3A; convB = 5;
    pulseStart(1, 0);
    waitValid(1, 0);
    check(dB == 14'h0C3A && fallB == 3, "R10 after", dB, 14'h0C3A);
    takeResult();

    check(oeSeen == 0, "R11 oe", oeSeen, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule